// File: doc/BRIEF.md
# Framed Serial Codec Link Master

This block drives a synchronous, frame-based serial link to one or two codec devices and is always the clock and frame master. It divides the system clock by a programmable ratio to make the serial clock, counts serial clock cycles into fixed 128-cycle frames, and marks each frame with a single-cycle sync pulse. Each frame is split into two 64-bit subframes. Subframe 0 goes to the first device and subframe 1 to the second. Data moves in both directions at once.

Software loads a transmit holding register for each subframe and reads a receive register for each subframe. The holding registers are copied into the transmit shifter when a frame starts. Each received subframe is copied into its receive register when that subframe's last bit arrives. A per-subframe enable lets software mute one subframe. A sticky frame-done flag, with a maskable interrupt, marks every completed frame.

Top module: `codec_link_master`

## Requirements
- R1: After reset, `sclk`, `sync`, `sdout`, `done` and `irq` are low and both receive words are zero. While `run` is low, `sclk`, `sync` and `sdout` stay low.
- R2: While `run` is high, `sclk` has a period of 2·max(`half_div`,1) system clock cycles, with equal high and low halves. A `half_div` of 0 behaves like 1.
- R3: A frame lasts exactly 128 serial clock cycles, so `sync` rises once every 128 serial cycles.
- R4: `sync` is high for exactly one serial cycle. That cycle comes just before bit 0 of a frame and overlaps the last bit of the previous frame. The first serial cycle after `run` rises is a sync cycle.
- R5: Serial bits 0–63 of a frame carry subframe 0 and bits 64–127 carry subframe 1, each most significant bit first. `sdout` and `sync` change only at rising edges of `sclk`.
- R6: `sdin` is sampled at the rising `sclk` edge that ends each serial cycle. `rx_word0` takes bits 0–63 after bit 63, and `rx_word1` takes bits 64–127 after bit 127. The first bit received lands in bit 63 of the word.
- R7: When `sub_en[i]` is 0 at the start of a frame, subframe i is sent as all zeros. When `sub_en[i]` is 0 at the end of subframe i, that receive word keeps its old value.
- R8: `done` sets at the end of every complete frame and never for the partial frame that follows `run` rising. It stays set until `done_clr` is asserted; a set in the same cycle wins over the clear. `irq` equals `done` AND `irq_en`.
- R9: The transmit holding registers are copied into the shifter at frame start. A write through `tx_wr[i]` during a frame takes effect from the next frame.
- R10: Dropping `run` in mid-frame returns the link to idle at once. Raising `run` again starts from a fresh sync cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, source of the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Link enable; low holds the link idle |
| half_div | input | DIVW | Serial clock half period in system clocks (0 treated as 1) |
| sub_en | input | 2 | Per-subframe enable |
| irq_en | input | 1 | Interrupt enable for the frame-done flag |
| tx_wr | input | 2 | Write strobe per transmit holding register |
| tx_wdata | input | SUBW | Data written to the selected holding register |
| done_clr | input | 1 | Clears the frame-done flag |
| sdin | input | 1 | Serial data from the codecs |
| sclk | output | 1 | Serial clock |
| sync | output | 1 | Frame sync, one serial cycle before each frame |
| sdout | output | 1 | Serial data to the codecs |
| rx_word0 | output | SUBW | Last received subframe 0 |
| rx_word1 | output | SUBW | Last received subframe 1 |
| done | output | 1 | Frame-done status flag |
| irq | output | 1 | Frame-done interrupt |

## Verification
The bench plays the part of a codec. It rebuilds every frame bit by bit from the sync pulse and answers with its own 128-bit pattern. The divider is swept over several ratios, including the zero case. In that sweep the transmit and receive words are tied to the ratio, so a swapped subframe, a reversed bit order or an off-by-one in the bit counter shows up as a pattern mismatch, not a timing error. Separate runs mute one subframe, rewrite a holding register in mid-frame, and drop `run` in mid-frame. These runs separate copy-at-frame-start from copy-at-write, and a fresh startup from a resumed one.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;
  localparam int NSUB = 2;

  // effective half period of the serial clock, in system clocks
  function automatic int unsigned eff_half(input int unsigned h);
    return (h == 0) ? 32'd1 : h;
  endfunction

  // serial bit position that follows pos in a frame of len cycles
  function automatic int unsigned next_pos(input int unsigned pos, input int unsigned len);
    return (pos == len - 1) ? 32'd0 : pos + 32'd1;
  endfunction
endpackage

// File: rtl/codec_link_clkdiv.sv
module codec_link_clkdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] half_div,
  output logic            sclk,
  output logic            rise_tick
);
  import codec_link_pkg::*;

  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] lim;
  logic            wrap;

  assign lim       = DIVW'(eff_half(32'(half_div)) - 32'd1);
  assign wrap      = run && (cnt == lim);
  assign rise_tick = wrap && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: every rise event really produces a high serial clock
  a_r2_tick_rises: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> sclk);

  // R10: an idle link keeps the serial clock low
  a_r10_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);
endmodule

// File: rtl/codec_link_framer.sv
module codec_link_framer #(
  parameter int FRAME = 128,
  localparam int BW   = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rise_tick,
  output logic [BW-1:0] bitc,
  output logic          sync,
  output logic          frame_start,
  output logic          primed
);
  import codec_link_pkg::*;

  logic [BW-1:0] nxt;

  assign nxt         = BW'(next_pos(32'(bitc), FRAME));
  assign frame_start = rise_tick && (nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitc   <= BW'(FRAME - 2);
      sync   <= 1'b0;
      primed <= 1'b0;
    end else if (!run) begin
      bitc   <= BW'(FRAME - 2);
      sync   <= 1'b0;
      primed <= 1'b0;
    end else if (rise_tick) begin
      bitc <= nxt;
      sync <= (nxt == BW'(FRAME - 1));
      if (frame_start) primed <= 1'b1;
    end
  end

  // R4: sync never lasts past one serial cycle
  a_r4_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && rise_tick) |=> !sync);

  // R3: a frame only begins out of a sync cycle
  a_r3_start_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> sync);
endmodule

// File: rtl/codec_link_shifter.sv
module codec_link_shifter #(
  parameter int SUBW  = 64,
  parameter int NSUB  = 2,
  localparam int FRAME = SUBW * NSUB,
  localparam int BW    = $clog2(FRAME)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      rise_tick,
  input  logic                      frame_start,
  input  logic                      primed,
  input  logic [BW-1:0]             bitc,
  input  logic [NSUB-1:0]           sub_en,
  input  logic [NSUB-1:0][SUBW-1:0] hold,
  input  logic                      sdin,
  output logic                      sdout,
  output logic [NSUB-1:0][SUBW-1:0] rx,
  output logic [NSUB-1:0]           sub_end
);
  logic [FRAME-1:0] load_vec;
  logic [FRAME-1:0] txsh;
  logic [SUBW-1:0]  rxsh;
  logic [SUBW-1:0]  rx_next;

  // subframe 0 occupies the top bits so it leaves first
  always_comb begin
    load_vec = '0;
    for (int i = 0; i < NSUB; i++)
      load_vec[FRAME-1-i*SUBW -: SUBW] = sub_en[i] ? hold[i] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh  <= '0;
      sdout <= 1'b0;
    end else if (!run) begin
      txsh  <= '0;
      sdout <= 1'b0;
    end else if (rise_tick) begin
      if (frame_start) begin
        sdout <= load_vec[FRAME-1];
        txsh  <= load_vec << 1;
      end else begin
        sdout <= txsh[FRAME-1];
        txsh  <= txsh << 1;
      end
    end
  end

  assign rx_next = {rxsh[SUBW-2:0], sdin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rxsh <= '0;
    else if (rise_tick) rxsh <= rx_next;
  end

  for (genvar g = 0; g < NSUB; g++) begin : g_rx
    logic [SUBW-1:0] word_q;
    assign sub_end[g] = rise_tick && primed && (bitc == BW'((g + 1) * SUBW - 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       word_q <= '0;
      else if (sub_end[g] && sub_en[g]) word_q <= rx_next;
    end
    assign rx[g] = word_q;
  end

  // R7: a muted first subframe starts with a zero bit
  a_r7_muted_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !sub_en[0]) |=> !sdout);

  // R7: a muted subframe keeps its receive word
  a_r7_muted_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_end[0] && !sub_en[0]) |=> $stable(rx[0]));

  // R10: idle link drives no data
  a_r10_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sdout);
endmodule

// File: rtl/codec_link_master.sv
module codec_link_master #(
  parameter int DIVW = 8,
  parameter int SUBW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] half_div,
  input  logic [1:0]      sub_en,
  input  logic            irq_en,
  input  logic [1:0]      tx_wr,
  input  logic [SUBW-1:0] tx_wdata,
  input  logic            done_clr,
  input  logic            sdin,
  output logic            sclk,
  output logic            sync,
  output logic            sdout,
  output logic [SUBW-1:0] rx_word0,
  output logic [SUBW-1:0] rx_word1,
  output logic            done,
  output logic            irq
);
  localparam int NSUB  = codec_link_pkg::NSUB;
  localparam int FRAME = NSUB * SUBW;
  localparam int BW    = $clog2(FRAME);

  logic                      rise_tick;
  logic [BW-1:0]             bitc;
  logic                      frame_start;
  logic                      primed;
  logic [NSUB-1:0]           sub_end;
  logic                      frame_end;
  logic [NSUB-1:0][SUBW-1:0] hold;
  logic [NSUB-1:0][SUBW-1:0] rx;

  codec_link_clkdiv #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div),
    .sclk(sclk), .rise_tick(rise_tick)
  );

  codec_link_framer #(.FRAME(FRAME)) u_frm (
    .clk(clk), .rst_n(rst_n), .run(run), .rise_tick(rise_tick),
    .bitc(bitc), .sync(sync), .frame_start(frame_start), .primed(primed)
  );

  codec_link_shifter #(.SUBW(SUBW), .NSUB(NSUB)) u_shf (
    .clk(clk), .rst_n(rst_n), .run(run), .rise_tick(rise_tick),
    .frame_start(frame_start), .primed(primed), .bitc(bitc),
    .sub_en(sub_en), .hold(hold), .sdin(sdin), .sdout(sdout),
    .rx(rx), .sub_end(sub_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= '0;
    else begin
      for (int i = 0; i < NSUB; i++)
        if (tx_wr[i]) hold[i] <= tx_wdata;
    end
  end

  assign frame_end = sub_end[NSUB-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done <= 1'b0;
    else if (frame_end) done <= 1'b1;
    else if (done_clr)  done <= 1'b0;
  end

  assign irq      = done && irq_en;
  assign rx_word0 = rx[0];
  assign rx_word1 = rx[1];

  // R8: the end of a frame always raises the flag
  a_r8_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> done);

  // R8: the flag is sticky until software clears it
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);

  // R6: receive words only move at a subframe boundary
  a_r6_rx1_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_end[1] |=> $stable(rx_word1));
endmodule

// File: tb/codec_link_master_test.sv
module codec_link_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [7:0]  half_div = 8'd1;
  logic [1:0]  sub_en = 2'b11;
  logic        irq_en = 1'b0;
  logic [1:0]  tx_wr = 2'b00;
  logic [63:0] tx_wdata = '0;
  logic        done_clr = 1'b0;
  logic        sdin;
  logic        sclk, sync, sdout, done, irq;
  logic [63:0] rx_word0, rx_word1;

  int total = 0;
  int bad = 0;

  codec_link_master uut (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div),
    .sub_en(sub_en), .irq_en(irq_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .done_clr(done_clr), .sdin(sdin), .sclk(sclk), .sync(sync),
    .sdout(sdout), .rx_word0(rx_word0), .rx_word1(rx_word1),
    .done(done), .irq(irq)
  );

  always #10 clk = ~clk;

  // codec model: rebuilds frames from sync, answers with pat
  logic [127:0] pat = '0;
  logic [127:0] cap = '0;
  logic [127:0] last_frame = '0;
  logic         sclk_d = 1'b0;
  logic         sync_prev = 1'b0;
  logic         first_sync = 1'b0;
  int cur = -1;
  int nframes = 0;
  int rises = 0;
  int since_run = 0;
  int clkcount = 0;
  int last_rise = 0;
  int gap = 0;
  int last_sync_idx = -1;
  int sync_gap = 0;
  int sync_wide = 0;

  always @(negedge clk) begin
    clkcount = clkcount + 1;
    if (!run) begin
      cur = -1; sync_prev = 1'b0; since_run = 0; nframes = 0;
      sdin = 1'b0; last_sync_idx = -1;
    end else if (sclk && !sclk_d) begin
      rises = rises + 1;
      since_run = since_run + 1;
      gap = clkcount - last_rise;
      last_rise = clkcount;
      if (since_run == 1) first_sync = sync;
      if (sync_prev) cur = 0;
      else if (cur >= 0) cur = cur + 1;
      if (cur >= 0 && cur < 128) begin
        cap[127-cur] = sdout;
        sdin = pat[127-cur];
        if (cur == 127) begin
          last_frame = cap;
          nframes = nframes + 1;
        end
      end else sdin = 1'b0;
      if (sync) begin
        if (sync_prev) sync_wide = sync_wide + 1;
        if (last_sync_idx >= 0) sync_gap = rises - last_sync_idx;
        last_sync_idx = rises;
      end
      sync_prev = sync;
    end
    sclk_d = sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_hold(input int idx, input logic [63:0] v);
    @(negedge clk);
    tx_wdata = v;
    tx_wr = (idx == 0) ? 2'b01 : 2'b10;
    @(negedge clk);
    tx_wr = 2'b00;
  endtask

  task automatic clear_done();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int r;
    wait (nframes >= n);
    r = rises;
    wait (rises > r);
    @(negedge clk);
  endtask

  task automatic stop_link();
    @(negedge clk); run = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int eff;
    logic [63:0] p0, p1, t0, t1, old1;
    #5;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sclk, sync, sdout, done, irq} == 5'b0, "R1 reset outputs", 128'({sclk, sync, sdout, done, irq}), 0);
    chk({rx_word0, rx_word1} == '0, "R1 reset rx words", {rx_word0, rx_word1}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({sclk, sync, sdout} == 3'b0, "R1 idle while run low", 128'({sclk, sync, sdout}), 0);

    // divider / data sweep
    foreach (p0[k]) begin end
    for (int h = 0; h < 6; h++) begin
      if (h == 4) continue;
      eff = (h == 0) ? 1 : h;
      p0 = 64'h0123_4567_89AB_CDEF ^ {8{8'(h * 37)}};
      p1 = {p0[31:0], p0[63:32]} ^ 64'hFFFF_0000_FFFF_0000;
      t0 = p0 ^ 64'h5A5A_5A5A_0F0F_0F0F;
      t1 = ~p1 + 64'(h);
      write_hold(0, t0);
      write_hold(1, t1);
      pat = {p0, p1};
      half_div = 8'(h);
      irq_en = h[0];
      sub_en = 2'b11;
      @(negedge clk); run = 1'b1;
      wait_frames(2);
      chk(gap == 2 * eff, $sformatf("R2 sclk period h=%0d", h), 128'(gap), 128'(2 * eff));
      chk(sync_gap == 128, "R3 sync spacing", 128'(sync_gap), 128);
      chk(sync_wide == 0, "R4 sync width", 128'(sync_wide), 0);
      chk(first_sync == 1'b1, "R4 first cycle is sync", 128'(first_sync), 1);
      chk(last_frame == {t0, t1}, "R5 transmitted frame", last_frame, {t0, t1});
      chk(rx_word0 == p0, "R6 rx_word0", 128'(rx_word0), 128'(p0));
      chk(rx_word1 == p1, "R6 rx_word1", 128'(rx_word1), 128'(p1));
      chk(done == 1'b1, "R8 done after frame", 128'(done), 1);
      chk(irq == h[0], "R8 irq follows enable", 128'(irq), 128'(h[0]));
      clear_done();
      chk(done == 1'b0, "R8 done cleared", 128'(done), 0);
      stop_link();
      chk({sclk, sync, sdout} == 3'b0, "R10 idle after stop", 128'({sclk, sync, sdout}), 0);
    end

    // R7 muted subframe 1
    old1 = rx_word1;
    p0 = 64'hFEDC_BA98_7654_3210;
    p1 = 64'h1111_2222_3333_4444;
    pat = {p0, p1};
    write_hold(0, 64'hC3C3_0000_FFFF_1234);
    write_hold(1, 64'hFFFF_FFFF_FFFF_FFFF);
    half_div = 8'd1;
    sub_en = 2'b01;
    @(negedge clk); run = 1'b1;
    wait_frames(2);
    chk(last_frame[63:0] == 64'h0, "R7 muted subframe sends zeros", 128'(last_frame[63:0]), 0);
    chk(last_frame[127:64] == 64'hC3C3_0000_FFFF_1234, "R5 live subframe", 128'(last_frame[127:64]), 128'(64'hC3C3_0000_FFFF_1234));
    chk(rx_word1 == old1, "R7 muted rx word kept", 128'(rx_word1), 128'(old1));
    chk(rx_word0 == p0, "R6 live rx word", 128'(rx_word0), 128'(p0));
    stop_link();

    // R9 holding register handoff in mid-frame
    sub_en = 2'b11;
    write_hold(0, 64'hAAAA_AAAA_AAAA_AAAA);
    write_hold(1, 64'h0F0F_0F0F_0F0F_0F0F);
    @(negedge clk); run = 1'b1;
    wait (nframes >= 1 && cur == 10);
    write_hold(0, 64'h5555_0000_5555_0000);
    wait_frames(2);
    chk(last_frame[127:64] == 64'hAAAA_AAAA_AAAA_AAAA, "R9 write waits for next frame",
        128'(last_frame[127:64]), 128'(64'hAAAA_AAAA_AAAA_AAAA));
    wait_frames(3);
    chk(last_frame[127:64] == 64'h5555_0000_5555_0000, "R9 new hold used next frame",
        128'(last_frame[127:64]), 128'(64'h5555_0000_5555_0000));

    // R10 stop mid-frame, restart; R8 no done for partial frame
    wait (cur == 40);
    stop_link();
    chk({sclk, sync, sdout} == 3'b0, "R10 idle after mid-frame stop", 128'({sclk, sync, sdout}), 0);
    clear_done();
    @(negedge clk); run = 1'b1;
    wait (cur == 5);
    @(negedge clk);
    chk(first_sync == 1'b1, "R10 restart begins with sync", 128'(first_sync), 1);
    chk(done == 1'b0, "R8 no done from partial frame", 128'(done), 0);
    stop_link();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule